// File: doc/BRIEF.md
# Address Translator with Lookaside Buffer and Page-Fault Allocation

This block maps 16-bit virtual addresses onto physical addresses with 4 KB pages. The low twelve bits are the page offset and pass straight through. The top four bits are the virtual page number. That number is first looked up in a small fully associative lookaside buffer of four entries. If the buffer misses, a sixteen-entry page table held in flip-flops is read. If the page-table entry is also invalid, the page counts as non-resident. The block then takes a fresh physical page number from an allocation counter and writes it into both structures. No data is transferred.

A request is offered with `req_valid` and is accepted in any cycle where `req_ready` is high. Each accepted request produces exactly one single-cycle response. The response carries the physical address and a two-bit outcome code. A buffer hit answers on the next cycle. A buffer miss holds `req_ready` low for `MISS_LAT` cycles and then answers. Before traffic starts, a write port preloads buffer and page-table entries. A one-cycle `cfg_done` pulse then seeds the allocation counter from the preloaded contents.

Top module: `tlb_xlate`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0, every buffer and page-table entry is invalid, and the allocation counter is 0.
- R2: The response address is `{ppn, va[11:0]}`: the offset bits of the accepted address appear unchanged in the low twelve bits.
- R3: When the page is present in a valid buffer entry, `rsp_valid` rises in the cycle after acceptance with `rsp_code` = 0. Back-to-back hits may be accepted on consecutive cycles.
- R4: On a buffer miss, `req_ready` is low for `MISS_LAT` cycles after acceptance. The response arrives together with `req_ready` returning high, `MISS_LAT` cycles after acceptance.
- R5: On a buffer miss where the page-table entry is valid, the response has `rsp_code` = 1 and that entry's physical page. The mapping is loaded into the buffer, so a repeat access to that page hits.
- R6: On a buffer miss where the page-table entry is invalid, the response has `rsp_code` = 2 and the physical page equal to the allocation counter. That page is written as valid into the page table and into the buffer, and the counter then increments by one.
- R7: A `cfg_done` pulse sets the allocation counter to one more than the largest physical page held in any valid buffer or page-table entry. If no entry is valid, the counter is set to 0.
- R8: When a mapping is loaded into the buffer and an invalid entry exists, the lowest-numbered invalid entry receives it.
- R9: When all buffer entries are valid, the entry least recently hit or loaded is replaced. After reset the entries count as used most recently in order 0, 1, 2, 3, so entry 3 is the oldest.
- R10: `rsp_code` only takes the values 0, 1 or 2, and `rsp_valid` is high for exactly one cycle per accepted request.
- R11: While `cfg_we` is high, `req_ready` is low. The write targets buffer entry `cfg_idx[1:0]` when `cfg_tlb` = 1, and page-table entry `cfg_idx` when `cfg_tlb` = 0. The written fields are valid bit, tag and physical page. Buffer age order is not changed by a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Preload write strobe |
| cfg_tlb | input | 1 | 1 selects buffer entry, 0 selects page-table entry |
| cfg_idx | input | 4 | Entry index (buffer uses low 2 bits) |
| cfg_vld | input | 1 | Valid bit to write |
| cfg_vpn | input | 4 | Virtual page tag to write (buffer only) |
| cfg_ppn | input | 8 | Physical page to write |
| cfg_done | input | 1 | Pulse that seeds the allocation counter |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_va | input | 16 | Virtual address |
| rsp_valid | output | 1 | Response pulse |
| rsp_pa | output | 20 | Physical address |
| rsp_code | output | 2 | 0 buffer hit, 1 page-table hit, 2 page fault |

## Verification
The hardest case to reach is eviction of the true least-recently-used entry. Reaching it needs every buffer entry valid, then an access order that differs from both the install order and the reset age order, then one more miss. The stimulus gets there by preloading three entries and leaving one invalid. It then runs a stream mixing hits, page-table hits and faults, so that the invalid slot fills first and later faults evict entries aged by interleaved hits. It finally returns to evicted pages, which must come back as page-table hits through the fault-installed entries. A second reset covers counter seeding from buffer-only contents and from an empty configuration.

// File: rtl/tlb_xlate.sv
module tlb_xlate #(
  parameter int VA_W     = 16,
  parameter int OFF_W    = 12,
  parameter int PPN_W    = 8,
  parameter int TLB_N    = 4,
  parameter int MISS_LAT = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic                   cfg_tlb,
  input  logic [VA_W-OFF_W-1:0]  cfg_idx,
  input  logic                   cfg_vld,
  input  logic [VA_W-OFF_W-1:0]  cfg_vpn,
  input  logic [PPN_W-1:0]       cfg_ppn,
  input  logic                   cfg_done,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [VA_W-1:0]        req_va,
  output logic                   rsp_valid,
  output logic [PPN_W+OFF_W-1:0] rsp_pa,
  output logic [1:0]             rsp_code
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PT_N  = 1 << VPN_W;
  localparam int TI_W  = $clog2(TLB_N);
  localparam int CNT_W = $clog2(MISS_LAT + 1);
  localparam logic [1:0] C_TLB = 2'd0;
  localparam logic [1:0] C_PT  = 2'd1;
  localparam logic [1:0] C_FLT = 2'd2;

  logic [TLB_N-1:0] t_v;
  logic [VPN_W-1:0] t_tag [TLB_N];
  logic [PPN_W-1:0] t_ppn [TLB_N];
  logic [TI_W-1:0]  t_age [TLB_N];
  logic [PT_N-1:0]  p_v;
  logic [PPN_W-1:0] p_ppn [PT_N];

  logic             busy;
  logic [CNT_W-1:0] cnt;
  logic [VPN_W-1:0] h_vpn;
  logic [OFF_W-1:0] h_off;
  logic [PPN_W-1:0] next_ppn;

  logic [VPN_W-1:0] req_vpn;
  logic             accept, resolve, pt_hit;
  logic             hit_any, touch_en;
  logic [TI_W-1:0]  hit_idx, victim, touch_idx, touch_age;
  logic [PPN_W-1:0] fill_ppn, cfg_max;
  logic             cfg_any;

  assign req_vpn   = req_va[VA_W-1:OFF_W];
  assign req_ready = !busy && !cfg_we;
  assign accept    = req_valid && req_ready;
  assign resolve   = busy && (cnt == CNT_W'(1));
  assign pt_hit    = p_v[h_vpn];
  assign fill_ppn  = pt_hit ? p_ppn[h_vpn] : next_ppn;
  assign touch_en  = resolve || (accept && hit_any);
  assign touch_idx = resolve ? victim : hit_idx;
  assign touch_age = t_age[touch_idx];

  always_comb begin
    hit_any = 1'b0;
    hit_idx = '0;
    for (int i = 0; i < TLB_N; i++)
      if (t_v[i] && t_tag[i] == req_vpn) begin
        hit_any = 1'b1;
        hit_idx = TI_W'(i);
      end
  end

  always_comb begin
    victim = '0;
    for (int i = 0; i < TLB_N; i++)
      if (t_age[i] == TI_W'(TLB_N - 1)) victim = TI_W'(i);
    for (int i = TLB_N - 1; i >= 0; i--)
      if (!t_v[i]) victim = TI_W'(i);
  end

  always_comb begin
    cfg_any = 1'b0;
    cfg_max = '0;
    for (int i = 0; i < PT_N; i++)
      if (p_v[i] && p_ppn[i] >= cfg_max) begin
        cfg_any = 1'b1;
        cfg_max = p_ppn[i];
      end
    for (int i = 0; i < TLB_N; i++)
      if (t_v[i] && t_ppn[i] >= cfg_max) begin
        cfg_any = 1'b1;
        cfg_max = t_ppn[i];
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t_v       <= '0;
      p_v       <= '0;
      busy      <= 1'b0;
      cnt       <= '0;
      h_vpn     <= '0;
      h_off     <= '0;
      next_ppn  <= '0;
      rsp_valid <= 1'b0;
      rsp_pa    <= '0;
      rsp_code  <= C_TLB;
      for (int i = 0; i < TLB_N; i++) begin
        t_tag[i] <= '0;
        t_ppn[i] <= '0;
        t_age[i] <= TI_W'(i);
      end
      for (int i = 0; i < PT_N; i++) p_ppn[i] <= '0;
    end else begin
      rsp_valid <= 1'b0;

      if (cfg_we) begin
        if (cfg_tlb) begin
          t_v[cfg_idx[TI_W-1:0]]   <= cfg_vld;
          t_tag[cfg_idx[TI_W-1:0]] <= cfg_vpn;
          t_ppn[cfg_idx[TI_W-1:0]] <= cfg_ppn;
        end else begin
          p_v[cfg_idx]   <= cfg_vld;
          p_ppn[cfg_idx] <= cfg_ppn;
        end
      end

      if (cfg_done) next_ppn <= cfg_any ? cfg_max + 1'b1 : '0;

      if (accept) begin
        if (hit_any) begin
          rsp_valid <= 1'b1;
          rsp_pa    <= {t_ppn[hit_idx], req_va[OFF_W-1:0]};
          rsp_code  <= C_TLB;
        end else begin
          busy  <= 1'b1;
          cnt   <= CNT_W'(MISS_LAT);
          h_vpn <= req_vpn;
          h_off <= req_va[OFF_W-1:0];
        end
      end

      if (busy) begin
        if (resolve) begin
          busy           <= 1'b0;
          rsp_valid      <= 1'b1;
          rsp_pa         <= {fill_ppn, h_off};
          rsp_code       <= pt_hit ? C_PT : C_FLT;
          t_v[victim]    <= 1'b1;
          t_tag[victim]  <= h_vpn;
          t_ppn[victim]  <= fill_ppn;
          if (!pt_hit) begin
            p_v[h_vpn]   <= 1'b1;
            p_ppn[h_vpn] <= next_ppn;
            next_ppn     <= next_ppn + 1'b1;
          end
        end else begin
          cnt <= cnt - 1'b1;
        end
      end

      if (touch_en)
        for (int i = 0; i < TLB_N; i++)
          if (TI_W'(i) == touch_idx) t_age[i] <= '0;
          else if (t_age[i] < touch_age) t_age[i] <= t_age[i] + 1'b1;
    end
  end
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
  parameter int VA_W  = 16,
  parameter int OFF_W = 12,
  parameter int PPN_W = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cfg_we,
  input logic                   req_valid,
  input logic                   req_ready,
  input logic [VA_W-1:0]        req_va,
  input logic                   rsp_valid,
  input logic [PPN_W+OFF_W-1:0] rsp_pa,
  input logic [1:0]             rsp_code
);
  logic [OFF_W-1:0] held_off;

  always_ff @(posedge clk) begin
    if (!rst_n) held_off <= '0;
    else if (req_valid && req_ready) held_off <= req_va[OFF_W-1:0];
  end

  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_pa[OFF_W-1:0] == held_off); // R2
  AST_HIT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code == 2'd0) |-> $past(req_valid && req_ready)); // R3
  AST_MISS_WAITED: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code != 2'd0) |-> !$past(req_ready)); // R4
  AST_READY_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code != 2'd0 && !cfg_we) |-> req_ready); // R4
  AST_CODE_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_code != 2'd3); // R10
  AST_CFG_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> !req_ready); // R11
endmodule

bind tlb_xlate tlb_xlate_chk #(.VA_W(VA_W), .OFF_W(OFF_W), .PPN_W(PPN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .req_valid(req_valid),
  .req_ready(req_ready), .req_va(req_va), .rsp_valid(rsp_valid),
  .rsp_pa(rsp_pa), .rsp_code(rsp_code)
);

// File: tb/tlb_xlate_bench.sv
`timescale 1ns/1ps
module tlb_xlate_bench;
  localparam int MISS_LAT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_tlb = 1'b0, cfg_vld = 1'b0, cfg_done = 1'b0;
  logic [3:0]  cfg_idx = '0, cfg_vpn = '0;
  logic [7:0]  cfg_ppn = '0;
  logic        req_valid = 1'b0;
  logic [15:0] req_va = '0;
  logic        req_ready, rsp_valid;
  logic [19:0] rsp_pa;
  logic [1:0]  rsp_code;

  always #2.5 clk = ~clk;

  tlb_xlate #(.MISS_LAT(MISS_LAT)) u_tlb_xlate (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_tlb(cfg_tlb),
    .cfg_idx(cfg_idx), .cfg_vld(cfg_vld), .cfg_vpn(cfg_vpn), .cfg_ppn(cfg_ppn),
    .cfg_done(cfg_done), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_code(rsp_code)
  );

  int n_run = 0, n_fail = 0;
  string tag = "R1";

  bit     mt_v [4];
  int     mt_tag [4], mt_ppn [4];
  longint mt_use [4];
  bit     mp_v [16];
  int     mp_ppn [16];
  int     m_next, m_busy, pend_pa, pend_code, e_pa, e_code;
  bit     e_rv;
  longint m_time;

  task automatic chk(bit ok, string what, longint act, longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic void m_reset();
    for (int i = 0; i < 4; i++) begin
      mt_v[i] = 0; mt_tag[i] = 0; mt_ppn[i] = 0; mt_use[i] = -i;
    end
    for (int i = 0; i < 16; i++) begin mp_v[i] = 0; mp_ppn[i] = 0; end
    m_next = 0; m_busy = 0; e_rv = 0; m_time = 0;
  endfunction

  function automatic void m_translate(int va, output int pa, output int code);
    int vpn = (va >> 12) & 15;
    int ppn = 0;
    int slot = -1;
    for (int i = 0; i < 4; i++) if (mt_v[i] && mt_tag[i] == vpn) slot = i;
    if (slot >= 0) begin
      code = 0; ppn = mt_ppn[slot];
    end else begin
      if (mp_v[vpn]) begin
        code = 1; ppn = mp_ppn[vpn];
      end else begin
        code = 2; ppn = m_next;
        mp_v[vpn] = 1; mp_ppn[vpn] = ppn;
        m_next = (m_next + 1) & 255;
      end
      for (int i = 3; i >= 0; i--) if (!mt_v[i]) slot = i;
      if (slot < 0) begin
        slot = 0;
        for (int i = 1; i < 4; i++) if (mt_use[i] < mt_use[slot]) slot = i;
      end
      mt_v[slot] = 1; mt_tag[slot] = vpn; mt_ppn[slot] = ppn;
    end
    m_time++;
    mt_use[slot] = m_time;
    pa = (ppn << 12) | (va & 32'hfff);
  endfunction

  task automatic step();
    bit acc;
    acc = req_valid && (m_busy == 0) && !cfg_we;
    @(posedge clk);
    if (cfg_done) begin
      int mx = -1;
      for (int i = 0; i < 16; i++) if (mp_v[i] && mp_ppn[i] > mx) mx = mp_ppn[i];
      for (int i = 0; i < 4; i++) if (mt_v[i] && mt_ppn[i] > mx) mx = mt_ppn[i];
      m_next = (mx + 1) & 255;
    end
    if (cfg_we) begin
      if (cfg_tlb) begin
        mt_v[cfg_idx[1:0]] = cfg_vld; mt_tag[cfg_idx[1:0]] = cfg_vpn;
        mt_ppn[cfg_idx[1:0]] = cfg_ppn;
      end else begin
        mp_v[cfg_idx] = cfg_vld; mp_ppn[cfg_idx] = cfg_ppn;
      end
    end
    e_rv = 0;
    if (m_busy > 0) begin
      m_busy--;
      if (m_busy == 0) begin e_rv = 1; e_pa = pend_pa; e_code = pend_code; end
    end else if (acc) begin
      m_translate(req_va, pend_pa, pend_code);
      if (pend_code == 0) begin e_rv = 1; e_pa = pend_pa; e_code = 0; end
      else m_busy = MISS_LAT;
    end
    @(negedge clk);
    chk(req_ready === ((m_busy == 0) && !cfg_we), "req_ready", req_ready, (m_busy == 0) && !cfg_we);
    chk(rsp_valid === e_rv, "rsp_valid", rsp_valid, e_rv);
    if (e_rv) begin
      chk(rsp_pa === 20'(e_pa), "rsp_pa", rsp_pa, e_pa);
      chk(rsp_code === 2'(e_code), "rsp_code", rsp_code, e_code);
    end
  endtask

  task automatic req(int va);
    req_valid = 1'b1; req_va = 16'(va);
    step();
    req_valid = 1'b0;
    while (m_busy > 0) step();
  endtask

  task automatic cfg_w(bit to_tlb, int idx, bit v, int vpn, int ppn);
    cfg_we = 1'b1; cfg_tlb = to_tlb; cfg_idx = 4'(idx); cfg_vld = v;
    cfg_vpn = 4'(vpn); cfg_ppn = 8'(ppn);
    step();
    cfg_we = 1'b0;
  endtask

  task automatic seed();
    cfg_done = 1'b1; step(); cfg_done = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    m_reset();
    rst_n = 1'b1;
    @(negedge clk);
    tag = "R1";
    chk(req_ready === 1'b1, "reset ready", req_ready, 1);
    chk(rsp_valid === 1'b0, "reset rsp_valid", rsp_valid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    m_reset();
    do_reset();
    tag = "R1 R6";
    req(16'h1abc);
    req(16'h2001);
    tag = "R3";
    req(16'h1fff);

    do_reset();
    tag = "R11";
    cfg_w(1, 0, 1, 11, 12);
    cfg_w(1, 1, 1, 7, 4);
    cfg_w(1, 2, 1, 3, 6);
    cfg_w(1, 3, 0, 4, 9);
    begin
      int pv [16] = '{1,0,0,1,1,1,0,1,0,0,1,1,0,0,0,0};
      int pp [16] = '{5,0,0,6,9,11,0,4,0,0,3,12,0,0,0,0};
      for (int i = 0; i < 16; i++) cfg_w(0, i, pv[i], 0, pp[i]);
    end
    tag = "R7";
    seed();
    tag = "R5 R8";
    req(4095);
    tag = "R3 R2";
    req(31272);
    req(15789);
    tag = "R6 R9";
    req(7193);
    tag = "R3";
    req(4096);
    tag = "R6 R9";
    req(8912);
    tag = "R5 R9";
    foreach (pp_stream[i]) req(pp_stream[i]);
    tag = "R3 R10";
    req_valid = 1'b1;
    for (int i = 0; i < 4; i++) begin
      req_va = 16'((i * 16'h1000) + 16'h0123);
      step();
      while (m_busy > 0) step();
    end
    req_valid = 1'b0;
    step();

    do_reset();
    tag = "R7";
    cfg_w(1, 2, 1, 9, 200);
    seed();
    req(16'h5555);
    do_reset();
    seed();
    req(16'h6006);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  int pp_stream [7] = '{9452, 30964, 19136, 46502, 38110, 16653, 48480};
endmodule